// File: doc/BRIEF.md
# Synchronous Burst Memory Wait Controller

This block is the device-side control of a synchronous burst pseudo-static memory. On each rising clock edge it samples an active-low chip select, an active-low address-valid strobe and a write-enable strobe. A burst starts on the edge where both chip select and address-valid are low while the block is idle. The block then counts a programmable initial latency and transfers a fixed number of 16-bit words between the pins and a small internal array. During a burst the word address steps linearly and wraps inside an aligned window the size of the burst.

A WAIT output tells the host when the data bus carries valid words. WAIT moves to its ready level one clock before the first data word, for both reads and writes, and its active level is chosen by a configuration bit. The host can end a burst early by raising chip select, which makes 1-word and 2-word transfers possible with any configured length. A start request that arrives while a burst is still running is dropped.

The bus pins are modelled as separate value and enable signals. An enable that is low stands for a high-impedance pin.

Top module: `burst_psram_ctrl`

## Requirements
- R1: After reset the block is idle, `dqOe` is low, and the configuration is latency 5, burst length 4 and WAIT polarity 0.
- R2: A burst starts on the rising edge where `csN` and `advN` are both low while the block is idle. That edge is cycle 0 and latches `addr`. `weN` sampled low on that edge selects a write and high selects a read.
- R3: For a read with latency L and length B, word k is driven on `dqOut` with `dqOe` high during the cycle that begins at edge L+k, for k = 0..B-1. `dqOe` is low in every other cycle.
- R4: For a write, the value on `dqIn` during the cycle that begins at edge L+k is stored as word k on edge L+k+1.
- R5: While `csN` is low, WAIT is at its ready level from the cycle that begins at edge L-1 through the last data cycle, and at its not-ready level at all other times. This applies to reads and to writes.
- R6: With polarity bit 0, the ready level of `waitOut` is 1 and the not-ready level is 0. With polarity bit 1 the two levels are swapped.
- R7: `waitOe` is high exactly when `csN` is low.
- R8: The configuration is loaded from `cfgData` on a rising edge with `cfgWe` high while no burst is active, and is ignored otherwise. Bits [2:0] give the latency: codes 3 to 7 give that many clocks and codes 0 to 2 give 3. Bits [4:3] give the length: 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 4. Bit 5 is the WAIT polarity.
- R9: Word k of a burst of length B from base address A uses address (A with its low log2(B) bits cleared) OR ((A + k) mod B).
- R10: A rising edge with `csN` high during a burst ends it at once. No further word is driven or stored, and a new burst may start on the following edge.
- R11: A start request sampled while a burst is active, including on its last data cycle, is ignored and does not change the burst address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| advN | input | 1 | Address valid, active low |
| weN | input | 1 | Write enable sampled at burst start, active low |
| addr | input | ADDR_W (6) | Word address of the burst |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 6 | Configuration value: polarity, length code, latency code |
| dqIn | input | DATA_W (16) | Write data from the host |
| dqOut | output | DATA_W (16) | Read data to the host |
| dqOe | output | 1 | Data bus drive enable; low means high-impedance |
| waitOut | output | 1 | WAIT level |
| waitOe | output | 1 | WAIT drive enable; low means high-impedance |

## Verification
Two functions can fall on the same clock edge: the end of a running burst and a new start request. The bench raises `advN` low with a different address during a burst's last data cycle, and also during its latency. It judges the result by the read words that follow, which must come from the original address, and by an idle WAIT level in the cycle after the burst ends. A second pair is a chip-select release that lands on a data cycle. Here the bench checks that the word and WAIT are withdrawn in that cycle, and that WAIT reads not-ready once chip select is low again without a new start.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int BEAT_W = 4;
  localparam int CNT_W  = 4;
  localparam int CFG_W  = 6;

  typedef struct packed {
    logic       polHigh;
    logic [1:0] lenCode;
    logic [2:0] latCode;
  } cfg_t;

  typedef struct packed {
    logic              capture;
    logic              busy;
    logic              waitReady;
    logic              driveData;
    logic              writeBeat;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] lenMask;
    logic              polHigh;
  } strobe_t;

  function automatic logic [CNT_W-1:0] latencyOf(input logic [2:0] code);
    return (code < 3'd3) ? CNT_W'(3) : CNT_W'(code);
  endfunction

  function automatic logic [BEAT_W-1:0] maskOf(input logic [1:0] code);
    case (code)
      2'd1:    return BEAT_W'(7);
      2'd2:    return BEAT_W'(15);
      default: return BEAT_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csN,
  input  logic             advN,
  input  logic             weN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  output strobe_t          st,
  output logic [CFG_W-1:0] cfgBits
);

  typedef enum logic [1:0] {S_IDLE, S_LAT, S_DATA} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [BEAT_W-1:0] beat;
  logic              isWrite;
  cfg_t              cfgQ;

  logic [CNT_W-1:0]  latency;
  logic [BEAT_W-1:0] lenMask;
  logic              startReq;
  logic              latDone;

  assign latency  = latencyOf(cfgQ.latCode);
  assign lenMask  = maskOf(cfgQ.lenCode);
  assign startReq = (state == S_IDLE) && !csN && !advN;
  assign latDone  = (cnt == latency - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgQ <= '{polHigh: 1'b0, lenCode: 2'd0, latCode: 3'd5};
    end else if (cfgWe && state == S_IDLE) begin
      cfgQ <= cfg_t'(cfgData);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      beat    <= '0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (startReq) begin
            state   <= S_LAT;
            cnt     <= '0;
            beat    <= '0;
            isWrite <= !weN;
          end
        end
        S_LAT: begin
          if (csN) begin
            state <= S_IDLE;
          end else if (latDone) begin
            state <= S_DATA;
            beat  <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_DATA: begin
          if (csN || beat == lenMask) begin
            state <= S_IDLE;
          end else begin
            beat <= beat + BEAT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st           = '0;
    st.capture   = startReq;
    st.busy      = (state != S_IDLE);
    st.waitReady = (state == S_DATA) || (state == S_LAT && latDone);
    st.driveData = (state == S_DATA) && !isWrite;
    st.writeBeat = (state == S_DATA) && isWrite && !csN;
    st.beat      = beat;
    st.lenMask   = lenMask;
    st.polHigh   = cfgQ.polHigh;
  end

  assign cfgBits = cfgQ;

endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic [ADDR_W-1:0] baseOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] maskWide;
  logic [ADDR_W-1:0] beatWide;
  logic [ADDR_W-1:0] curAddr;

  assign maskWide = ADDR_W'(st.lenMask);
  assign beatWide = ADDR_W'(st.beat);
  assign curAddr  = (baseQ & ~maskWide) | ((baseQ + beatWide) & maskWide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseQ <= '0;
    end else if (st.capture) begin
      baseQ <= addr;
    end
  end

  always_ff @(posedge clk) begin
    if (st.writeBeat) begin
      mem[curAddr] <= dqIn;
    end
  end

  assign dqOut   = mem[curAddr];
  assign baseOut = baseQ;

endmodule

// File: rtl/burst_psram_ctrl.sv
module burst_psram_ctrl
  import burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              advN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic              waitOut,
  output logic              waitOe
);

  strobe_t           st;
  logic [CFG_W-1:0]  cfgBits;
  logic [ADDR_W-1:0] baseQ;

  burst_ctrl uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .csN     (csN),
    .advN    (advN),
    .weN     (weN),
    .cfgWe   (cfgWe),
    .cfgData (cfgData),
    .st      (st),
    .cfgBits (cfgBits)
  );

  burst_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .addr    (addr),
    .dqIn    (dqIn),
    .dqOut   (dqOut),
    .baseOut (baseQ)
  );

  assign dqOe    = st.driveData && !csN;
  assign waitOe  = !csN;
  assign waitOut = st.waitReady ^ st.polHigh;

endmodule

// File: rtl/burst_psram_ctrl_chk.sv
module burst_psram_ctrl_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csN,
  input logic              advN,
  input logic              cfgWe,
  input logic              dqOe,
  input logic              waitOut,
  input logic              waitOe,
  input strobe_t           st,
  input logic [CFG_W-1:0]  cfgBits,
  input logic [ADDR_W-1:0] baseQ
);

  // R5: the pin showed ready in the cycle before read data appears
  a_r5_wait_leads_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqOe) |-> $past(waitOe && (waitOut ^ cfgBits[5])));

  // R10: chip select high during a burst ends it at that edge
  a_r10_stop_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (st.busy && csN) |=> !st.busy);

  // R11: a start request during a burst leaves the burst address alone
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st.busy && !csN && !advN) |=> $stable(baseQ));

  // R8: configuration writes during a burst have no effect
  a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (st.busy && cfgWe) |=> $stable(cfgBits));

  // R3: the beat index never passes the configured length
  a_r3_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    st.driveData |-> (st.beat <= st.lenMask));

endmodule

bind burst_psram_ctrl burst_psram_ctrl_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .csN     (csN),
  .advN    (advN),
  .cfgWe   (cfgWe),
  .dqOe    (dqOe),
  .waitOut (waitOut),
  .waitOe  (waitOe),
  .st      (st),
  .cfgBits (cfgBits),
  .baseQ   (baseQ)
);

// File: tb/tb_burst_psram_ctrl.sv
module tb_burst_psram_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csN, advN, weN, cfgWe;
  logic [5:0]  addr;
  logic [5:0]  cfgData;
  logic [15:0] dqIn;
  logic [15:0] dqOut;
  logic        dqOe, waitOut, waitOe;

  int          nRun = 0;
  int          nFail = 0;
  logic [15:0] model [64];

  always #4 clk = ~clk;

  burst_psram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .advN(advN), .weN(weN),
    .addr(addr), .cfgWe(cfgWe), .cfgData(cfgData), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe), .waitOut(waitOut), .waitOe(waitOe)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] wrapAddr(input logic [5:0] base, input int k, input int bl);
    logic [5:0] m;
    m = 6'(bl - 1);
    return (base & ~m) | ((base + 6'(k)) & m);
  endfunction

  task automatic setCfg(input int latCode, input int lenCode, input bit pol);
    @(negedge clk);
    cfgWe   = 1'b1;
    cfgData = {pol, 2'(lenCode), 3'(latCode)};
    @(negedge clk);
    cfgWe   = 1'b0;
  endtask

  // stopBeat < 0: full burst; pokeCycle < 0: no intrusion
  // pokeKind 0: start request, 1: configuration write
  task automatic runBurst(input string tag, input bit isWr, input logic [5:0] base,
                          input int lat, input int bl, input bit pol,
                          input int stopBeat, input int pokeCycle, input int pokeKind,
                          input logic [15:0] seed);
    int last;
    last = (stopBeat >= 0) ? lat + stopBeat : lat + bl;
    @(negedge clk);
    csN = 1'b0; advN = 1'b0; addr = base; weN = !isWr;
    for (int i = 0; i <= last; i++) begin
      int  beat;
      bit  inData;
      bit  ready;
      @(negedge clk);
      advN = 1'b1; cfgWe = 1'b0; addr = base;
      if (i == pokeCycle) begin
        if (pokeKind == 0) begin
          advN = 1'b0; addr = base ^ 6'h20;
        end else begin
          cfgWe = 1'b1; cfgData = 6'b010111;
        end
      end
      if (stopBeat >= 0 && i == last) csN = 1'b1;
      beat   = i - lat;
      inData = (beat >= 0) && (beat < bl) && !csN;
      ready  = (i >= lat - 1) && (i <= lat + bl - 1) && !csN;
      if (isWr && inData) begin
        dqIn = seed + 16'(beat);
        model[wrapAddr(base, beat, bl)] = seed + 16'(beat);
      end
      #1;
      chk({tag, " R7 wait enable"}, 32'(waitOe), 32'(!csN));
      if (!csN) chk({tag, " R5 R6 wait level"}, 32'(waitOut), 32'(ready ^ pol));
      chk({tag, " R3 data enable"}, 32'(dqOe), 32'(!isWr && inData));
      if (!isWr && inData)
        chk({tag, " R3 R9 read word"}, 32'(dqOut), 32'(model[wrapAddr(base, beat, bl)]));
    end
    @(negedge clk);
    csN = 1'b0; advN = 1'b1; cfgWe = 1'b0;
    #1;
    chk({tag, " R10 R11 idle wait after burst"}, 32'(waitOut), 32'(pol));
    chk({tag, " R10 idle data enable"}, 32'(dqOe), 32'd0);
    @(negedge clk);
    csN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; csN = 1'b1; advN = 1'b1; weN = 1'b1; cfgWe = 1'b0;
    addr = '0; cfgData = '0; dqIn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    chk("R1 R7 reset wait enable", 32'(waitOe), 32'd0);
    chk("R1 reset data enable", 32'(dqOe), 32'd0);
    @(negedge clk); csN = 1'b0; #1;
    chk("R1 reset wait level", 32'(waitOut), 32'd0);
    @(negedge clk); csN = 1'b1;

    // R1 R2 R4 default configuration write then read
    runBurst("R1 R2 R4 default write", 1'b1, 6'h10, 5, 4, 1'b0, -1, -1, 0, 16'hA100);
    runBurst("R1 R2 default read", 1'b0, 6'h10, 5, 4, 1'b0, -1, -1, 0, 16'h0);

    // R6 R8 R9 latency 3, length 8, polarity 1, wrapping
    setCfg(3, 1, 1'b1);
    runBurst("R6 R9 write wrap", 1'b1, 6'h23, 3, 8, 1'b1, -1, -1, 0, 16'hB200);
    runBurst("R6 R9 read wrap", 1'b0, 6'h25, 3, 8, 1'b1, -1, -1, 0, 16'h0);

    // R8 latency 7, length 16
    setCfg(7, 2, 1'b0);
    runBurst("R8 R4 write len16", 1'b1, 6'h00, 7, 16, 1'b0, -1, -1, 0, 16'hC300);
    runBurst("R8 R9 read len16", 1'b0, 6'h05, 7, 16, 1'b0, -1, -1, 0, 16'h0);

    // R8 low codes: latency code 0 gives 3, length code 3 gives 4
    setCfg(0, 3, 1'b0);
    runBurst("R8 clamp read", 1'b0, 6'h12, 3, 4, 1'b0, -1, -1, 0, 16'h0);

    // R10 early stops
    runBurst("R10 two word read", 1'b0, 6'h10, 3, 4, 1'b0, 2, -1, 0, 16'h0);
    runBurst("R10 one word read", 1'b0, 6'h01, 3, 4, 1'b0, 1, -1, 0, 16'h0);
    runBurst("R10 one word write", 1'b1, 6'h30, 3, 4, 1'b0, 1, -1, 0, 16'hD400);
    model[6'h31] = 16'h5555;
    runBurst("R10 fill rest", 1'b1, 6'h31, 3, 4, 1'b0, -1, -1, 0, 16'h5555);
    runBurst("R10 stop then read back", 1'b0, 6'h30, 3, 4, 1'b0, -1, -1, 0, 16'h0);

    // R11 start requests while busy
    runBurst("R11 start in latency", 1'b0, 6'h11, 3, 4, 1'b0, -1, 1, 0, 16'h0);
    runBurst("R11 start on last beat", 1'b0, 6'h13, 3, 4, 1'b0, -1, 6, 0, 16'h0);
    runBurst("R11 burst right after", 1'b0, 6'h30, 3, 4, 1'b0, -1, -1, 0, 16'h0);

    // R8 configuration write while busy is ignored
    runBurst("R8 cfg poke during burst", 1'b0, 6'h10, 3, 4, 1'b0, -1, 1, 1, 16'h0);
    runBurst("R8 cfg unchanged", 1'b0, 6'h22, 3, 4, 1'b0, -1, -1, 0, 16'h0);

    summary();
    $finish;
  end

endmodule